// File: doc/BRIEF.md
# Cycle-Stealing Single-Channel DMA Engine

This block moves bytes between a synchronous memory bus and one I/O device data port without the processor taking part. Software writes a start address, a unit count and a direction into three registers, then sets a start bit. The engine waits for the device to report a unit ready. It then requests the bus and, once granted, performs exactly one read and one write. After that it steps its address and count and gives the bus back.

Each unit is a separate bus ownership. The processor regains the bus between units, and the engine re-arbitrates for every byte. When the last unit has been written, the engine raises a level interrupt. The interrupt stays high until software clears it through the control register.

Top module: `cs_dma`

## Requirements
- R1: Register map at `reg_addr_i`. Offset 0 holds the memory address (16 bits) and offset 1 the remaining unit count (16 bits); reads of these offsets return the live values. A write to offset 2 is the control word: bit 0 start, bit 1 direction (0 = memory to device, 1 = device to memory), bit 2 interrupt clear. A read of offset 2 is the status word: bit 0 busy, bit 1 interrupt pending, bit 2 latched direction. Reset clears every register.
- R2: While the channel is busy, writes to the address and count registers and further start commands have no effect.
- R3: A unit begins, and `bus_req_o` rises, only after `dev_ready_i` has been seen high with the channel waiting.
- R4: No memory or device strobe is driven unless `bus_req_o` and `bus_gnt_i` are both high, and at most one strobe is active in any cycle. `mem_addr_o`, `mem_wdata_o` and `dev_wdata_o` are zero outside their strobes.
- R5: Each bus ownership carries exactly one read followed by one write. `bus_req_o` is low in the cycle after that write, and a transfer of N units makes N separate requests.
- R6: Memory-to-device: `mem_re_o` at the current address. In the next granted cycle, `dev_wr_o` presents the returned byte (memory read data arrives one cycle after the read strobe).
- R7: Device-to-memory: `dev_rd_o` captures `dev_rdata_i`. In the next granted cycle, `mem_we_o` writes that byte at the current address.
- R8: After each unit the address increments by one, wrapping at 16 bits, and the count decrements by one. At completion the address reads start + N and the count reads 0.
- R9: When the count reaches zero, `irq_o` rises in the same edge as the final step and busy falls. `irq_o` then stays high until a control write with bit 2 set.
- R10: Starting with a count of zero sets `irq_o` at the next edge and produces no request or strobe.
- R11: The busy status bit reads 1 from the edge that accepts a nonzero start until the final unit completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register offset |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data (combinational) |
| irq_o | output | 1 | Completion interrupt, level |
| bus_req_o | output | 1 | Bus request |
| bus_gnt_i | input | 1 | Bus grant |
| mem_re_o | output | 1 | Memory read strobe |
| mem_we_o | output | 1 | Memory write strobe |
| mem_addr_o | output | 16 | Memory address |
| mem_wdata_o | output | 8 | Memory write data |
| mem_rdata_i | input | 8 | Memory read data, valid one cycle after read |
| dev_ready_i | input | 1 | Device ready for the next unit |
| dev_rd_o | output | 1 | Device data read strobe |
| dev_rdata_i | input | 8 | Device data |
| dev_wr_o | output | 1 | Device data write strobe |
| dev_wdata_o | output | 8 | Device write data |

## Verification
The bench sweeps both directions across counts 0 to 7, with zero and delayed grants and with always-ready and sparse-ready devices. It also runs a transfer whose address wraps past 0xFFFF; a design that carried the wrap wrongly would land bytes at the wrong memory locations. It counts request rising edges per transfer, so an engine that held the bus for a whole block would show one request instead of N. It also checks that request falls the cycle after each write. A zero count must interrupt with no bus traffic; a design that decremented first would underflow and run 65536 units. Register writes and a second start issued mid-transfer must leave the address, the count, the direction and the unit total unchanged.

// File: rtl/cs_dma_pkg.sv
package cs_dma_pkg;
  localparam int unsigned REG_AW = 2;
  localparam logic [REG_AW-1:0] REG_ADDR = 2'd0;
  localparam logic [REG_AW-1:0] REG_CNT  = 2'd1;
  localparam logic [REG_AW-1:0] REG_CTRL = 2'd2;

  localparam int unsigned CTRL_START = 0;
  localparam int unsigned CTRL_DIR   = 1;
  localparam int unsigned CTRL_CLR   = 2;

  localparam int unsigned STAT_BUSY = 0;
  localparam int unsigned STAT_IRQ  = 1;
  localparam int unsigned STAT_DIR  = 2;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WAIT,
    ST_REQ,
    ST_RD,
    ST_WR
  } dma_st_e;
endpackage

// File: rtl/cs_dma_regs.sv
module cs_dma_regs
  import cs_dma_pkg::*;
#(
  parameter int unsigned AW = 16,
  parameter int unsigned CW = 16,
  parameter int unsigned RW = 32
) (
  input  logic              reg_we_i,
  input  logic [REG_AW-1:0] reg_addr_i,
  input  logic [RW-1:0]     reg_wdata_i,
  input  logic [AW-1:0]     addr_i,
  input  logic [CW-1:0]     cnt_i,
  input  logic              busy_i,
  input  logic              irq_i,
  input  logic              dir_i,
  output logic              addr_wr_o,
  output logic              cnt_wr_o,
  output logic              start_o,
  output logic              clr_o,
  output logic              dir_o,
  output logic [AW-1:0]     addr_wdata_o,
  output logic [CW-1:0]     cnt_wdata_o,
  output logic [RW-1:0]     reg_rdata_o
);
  logic ctrl_sel;
  logic unused_wdata;

  assign unused_wdata = ^reg_wdata_i;
  assign ctrl_sel     = reg_we_i && (reg_addr_i == REG_CTRL);
  assign addr_wr_o    = reg_we_i && (reg_addr_i == REG_ADDR);
  assign cnt_wr_o     = reg_we_i && (reg_addr_i == REG_CNT);
  assign start_o      = ctrl_sel && reg_wdata_i[CTRL_START];
  assign clr_o        = ctrl_sel && reg_wdata_i[CTRL_CLR];
  assign dir_o        = reg_wdata_i[CTRL_DIR];
  assign addr_wdata_o = reg_wdata_i[AW-1:0];
  assign cnt_wdata_o  = reg_wdata_i[CW-1:0];

  always_comb begin
    reg_rdata_o = '0;
    unique case (reg_addr_i)
      REG_ADDR: reg_rdata_o[AW-1:0] = addr_i;
      REG_CNT:  reg_rdata_o[CW-1:0] = cnt_i;
      REG_CTRL: begin
        reg_rdata_o[STAT_BUSY] = busy_i;
        reg_rdata_o[STAT_IRQ]  = irq_i;
        reg_rdata_o[STAT_DIR]  = dir_i;
      end
      default:  reg_rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/cs_dma_chan.sv
module cs_dma_chan #(
  parameter int unsigned AW = 16,
  parameter int unsigned CW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          addr_wr_i,
  input  logic          cnt_wr_i,
  input  logic          start_i,
  input  logic          clr_i,
  input  logic          dir_wdata_i,
  input  logic [AW-1:0] addr_wdata_i,
  input  logic [CW-1:0] cnt_wdata_i,
  input  logic          busy_i,
  input  logic          step_i,
  output logic [AW-1:0] addr_o,
  output logic [CW-1:0] cnt_o,
  output logic          dir_o,
  output logic          irq_o,
  output logic          go_o,
  output logic          last_o
);
  logic [AW-1:0] addr_q;
  logic [CW-1:0] cnt_q;
  logic          dir_q;
  logic          irq_q;
  logic          launch;
  logic          irq_set;

  // start is accepted only while idle
  assign launch  = start_i && !busy_i;
  assign go_o    = launch && (cnt_q != '0);
  assign last_o  = (cnt_q == CW'(1));
  assign irq_set = (launch && (cnt_q == '0)) || (step_i && last_o);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q <= '0;
      cnt_q  <= '0;
      dir_q  <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      if (step_i) begin
        addr_q <= addr_q + AW'(1);
        cnt_q  <= cnt_q - CW'(1);
      end else if (!busy_i) begin
        if (addr_wr_i) addr_q <= addr_wdata_i;
        if (cnt_wr_i)  cnt_q  <= cnt_wdata_i;
      end
      if (launch) dir_q <= dir_wdata_i;
      if (irq_set)    irq_q <= 1'b1;
      else if (clr_i) irq_q <= 1'b0;
    end
  end

  assign addr_o = addr_q;
  assign cnt_o  = cnt_q;
  assign dir_o  = dir_q;
  assign irq_o  = irq_q;
endmodule

// File: rtl/cs_dma_fsm.sv
module cs_dma_fsm
  import cs_dma_pkg::*;
#(
  parameter int unsigned AW = 16,
  parameter int unsigned DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          go_i,
  input  logic          dir_i,
  input  logic          last_i,
  input  logic [AW-1:0] addr_i,
  input  logic          dev_ready_i,
  input  logic          bus_gnt_i,
  input  logic [DW-1:0] mem_rdata_i,
  input  logic [DW-1:0] dev_rdata_i,
  output logic          busy_o,
  output logic          step_o,
  output logic          bus_req_o,
  output logic          mem_re_o,
  output logic          mem_we_o,
  output logic [AW-1:0] mem_addr_o,
  output logic [DW-1:0] mem_wdata_o,
  output logic          dev_rd_o,
  output logic          dev_wr_o,
  output logic [DW-1:0] dev_wdata_o
);
  dma_st_e       st_q, st_d;
  logic [DW-1:0] data_q;
  logic          rd_cyc, wr_cyc;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE: if (go_i)        st_d = ST_WAIT;
      ST_WAIT: if (dev_ready_i) st_d = ST_REQ;
      ST_REQ:  if (bus_gnt_i)   st_d = ST_RD;
      ST_RD:   if (bus_gnt_i)   st_d = ST_WR;
      ST_WR:   if (bus_gnt_i)   st_d = last_i ? ST_IDLE : ST_WAIT;
      default:                  st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      data_q <= '0;
    end else begin
      st_q <= st_d;
      if (dev_rd_o) data_q <= dev_rdata_i;
    end
  end

  // accesses stall while grant is withdrawn
  assign rd_cyc    = (st_q == ST_RD) && bus_gnt_i;
  assign wr_cyc    = (st_q == ST_WR) && bus_gnt_i;
  assign busy_o    = (st_q != ST_IDLE);
  assign step_o    = wr_cyc;
  assign bus_req_o = (st_q == ST_REQ) || (st_q == ST_RD) || (st_q == ST_WR);

  assign mem_re_o  = rd_cyc && !dir_i;
  assign dev_rd_o  = rd_cyc &&  dir_i;
  assign dev_wr_o  = wr_cyc && !dir_i;
  assign mem_we_o  = wr_cyc &&  dir_i;

  assign mem_addr_o  = (mem_re_o || mem_we_o) ? addr_i : '0;
  assign mem_wdata_o = mem_we_o ? data_q : '0;
  assign dev_wdata_o = dev_wr_o ? mem_rdata_i : '0;
endmodule

// File: rtl/cs_dma.sv
module cs_dma
  import cs_dma_pkg::*;
#(
  parameter int unsigned AW = 16,
  parameter int unsigned CW = 16,
  parameter int unsigned DW = 8,
  parameter int unsigned RW = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [REG_AW-1:0] reg_addr_i,
  input  logic [RW-1:0]     reg_wdata_i,
  output logic [RW-1:0]     reg_rdata_o,
  output logic              irq_o,
  output logic              bus_req_o,
  input  logic              bus_gnt_i,
  output logic              mem_re_o,
  output logic              mem_we_o,
  output logic [AW-1:0]     mem_addr_o,
  output logic [DW-1:0]     mem_wdata_o,
  input  logic [DW-1:0]     mem_rdata_i,
  input  logic              dev_ready_i,
  output logic              dev_rd_o,
  input  logic [DW-1:0]     dev_rdata_i,
  output logic              dev_wr_o,
  output logic [DW-1:0]     dev_wdata_o
);
  logic          addr_wr, cnt_wr, start, clr, dir_wdata;
  logic [AW-1:0] addr_wdata, addr;
  logic [CW-1:0] cnt_wdata, cnt;
  logic          busy, step, dir, go, last;

  cs_dma_regs #(.AW(AW), .CW(CW), .RW(RW)) regs_i (
    .reg_we_i     (reg_we_i),
    .reg_addr_i   (reg_addr_i),
    .reg_wdata_i  (reg_wdata_i),
    .addr_i       (addr),
    .cnt_i        (cnt),
    .busy_i       (busy),
    .irq_i        (irq_o),
    .dir_i        (dir),
    .addr_wr_o    (addr_wr),
    .cnt_wr_o     (cnt_wr),
    .start_o      (start),
    .clr_o        (clr),
    .dir_o        (dir_wdata),
    .addr_wdata_o (addr_wdata),
    .cnt_wdata_o  (cnt_wdata),
    .reg_rdata_o  (reg_rdata_o)
  );

  cs_dma_chan #(.AW(AW), .CW(CW)) chan_i (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .addr_wr_i    (addr_wr),
    .cnt_wr_i     (cnt_wr),
    .start_i      (start),
    .clr_i        (clr),
    .dir_wdata_i  (dir_wdata),
    .addr_wdata_i (addr_wdata),
    .cnt_wdata_i  (cnt_wdata),
    .busy_i       (busy),
    .step_i       (step),
    .addr_o       (addr),
    .cnt_o        (cnt),
    .dir_o        (dir),
    .irq_o        (irq_o),
    .go_o         (go),
    .last_o       (last)
  );

  cs_dma_fsm #(.AW(AW), .DW(DW)) fsm_i (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .go_i        (go),
    .dir_i       (dir),
    .last_i      (last),
    .addr_i      (addr),
    .dev_ready_i (dev_ready_i),
    .bus_gnt_i   (bus_gnt_i),
    .mem_rdata_i (mem_rdata_i),
    .dev_rdata_i (dev_rdata_i),
    .busy_o      (busy),
    .step_o      (step),
    .bus_req_o   (bus_req_o),
    .mem_re_o    (mem_re_o),
    .mem_we_o    (mem_we_o),
    .mem_addr_o  (mem_addr_o),
    .mem_wdata_o (mem_wdata_o),
    .dev_rd_o    (dev_rd_o),
    .dev_wr_o    (dev_wr_o),
    .dev_wdata_o (dev_wdata_o)
  );
endmodule

// File: rtl/cs_dma_chk.sv
module cs_dma_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       reg_we_i,
  input logic [1:0] reg_addr_i,
  input logic       clr_bit_i,
  input logic       irq_o,
  input logic       bus_req_o,
  input logic       bus_gnt_i,
  input logic       dev_ready_i,
  input logic       mem_re_o,
  input logic       mem_we_o,
  input logic       dev_rd_o,
  input logic       dev_wr_o
);
  logic any_strobe, rd_strobe, wr_strobe, clr_wr;

  assign rd_strobe  = mem_re_o || dev_rd_o;
  assign wr_strobe  = mem_we_o || dev_wr_o;
  assign any_strobe = rd_strobe || wr_strobe;
  assign clr_wr     = reg_we_i && (reg_addr_i == 2'd2) && clr_bit_i;

  // R4
  strobe_needs_gnt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    any_strobe |-> (bus_req_o && bus_gnt_i));

  // R4
  single_strobe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({mem_re_o, mem_we_o, dev_rd_o, dev_wr_o}));

  // R5
  req_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_strobe |=> !bus_req_o);

  // R5
  one_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_strobe |=> !rd_strobe);

  // R3
  ready_before_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(bus_req_o) |-> $past(dev_ready_i));

  // R9
  irq_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && !clr_wr) |=> irq_o);
endmodule

bind cs_dma cs_dma_chk chk_i (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .reg_we_i    (reg_we_i),
  .reg_addr_i  (reg_addr_i),
  .clr_bit_i   (reg_wdata_i[2]),
  .irq_o       (irq_o),
  .bus_req_o   (bus_req_o),
  .bus_gnt_i   (bus_gnt_i),
  .dev_ready_i (dev_ready_i),
  .mem_re_o    (mem_re_o),
  .mem_we_o    (mem_we_o),
  .dev_rd_o    (dev_rd_o),
  .dev_wr_o    (dev_wr_o)
);

// File: tb/cs_dma_tb_top.sv
module cs_dma_tb_top;
  localparam int AW = 16, CW = 16, DW = 8, RW = 32;

  logic clk = 1'b0, rst_n = 1'b0;
  always #5 clk = ~clk;

  logic          reg_we = 1'b0;
  logic [1:0]    reg_addr = '0;
  logic [RW-1:0] reg_wdata = '0;
  logic [RW-1:0] reg_rdata;
  logic          irq, req, gnt, mem_re, mem_we, dev_ready, dev_rd, dev_wr;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_wdata, mem_rdata, dev_rdata, dev_wdata;

  cs_dma #(.AW(AW), .CW(CW), .DW(DW), .RW(RW)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(reg_we), .reg_addr_i(reg_addr),
    .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata), .irq_o(irq),
    .bus_req_o(req), .bus_gnt_i(gnt), .mem_re_o(mem_re), .mem_we_o(mem_we),
    .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata), .mem_rdata_i(mem_rdata),
    .dev_ready_i(dev_ready), .dev_rd_o(dev_rd), .dev_rdata_i(dev_rdata),
    .dev_wr_o(dev_wr), .dev_wdata_o(dev_wdata)
  );

  // environment models
  logic [7:0] mem [256];
  logic [7:0] sink [64];
  logic [7:0] mem_q;
  logic       mem_load = 1'b0, mon_clr = 1'b0, rdy_slow = 1'b0;
  logic [7:0] src_seed = 8'h00;
  int         gnt_dly = 0;
  int         gcnt, cyc, sink_n, src_n, own_n, bad_n, late_n;
  logic       req_d, wr_d;

  always @(posedge clk) begin
    if (mem_load) begin
      for (int i = 0; i < 256; i++) mem[i] <= 8'(i * 7 + 3);
    end else if (mem_we) mem[mem_addr[7:0]] <= mem_wdata;
    if (mem_re) mem_q <= mem[mem_addr[7:0]];
  end
  assign mem_rdata = mem_q;

  always @(posedge clk) begin
    if (!req) gcnt <= 0;
    else if (gcnt < gnt_dly) gcnt <= gcnt + 1;
    cyc <= cyc + 1;
  end
  initial begin gcnt = 0; cyc = 0; end
  assign gnt       = req && (gcnt >= gnt_dly);
  assign dev_ready = rdy_slow ? (cyc % 3 == 0) : 1'b1;
  assign dev_rdata = 8'(src_seed + src_n * 13);

  always @(posedge clk) begin
    req_d <= req;
    wr_d  <= dev_wr | mem_we;
    if (mon_clr) begin
      sink_n <= 0; src_n <= 0; own_n <= 0; bad_n <= 0; late_n <= 0;
    end else begin
      if (dev_wr) begin sink[sink_n[5:0]] <= dev_wdata; sink_n <= sink_n + 1; end
      if (dev_rd) src_n <= src_n + 1;
      if (req && !req_d) own_n <= own_n + 1;
      if ((mem_re | mem_we | dev_rd | dev_wr) && !(req && gnt)) bad_n <= bad_n + 1;
      if (wr_d && req) late_n <= late_n + 1;
    end
  end

  int n_chk = 0, n_fail = 0;

  task automatic check(input bit ok, input string rq, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  task automatic reg_write(input logic [1:0] a, input logic [RW-1:0] d);
    @(negedge clk); reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_we = 1'b0; reg_wdata = '0;
  endtask

  task automatic reg_read(input logic [1:0] a, output logic [RW-1:0] d);
    reg_addr = a; #1; d = reg_rdata;
  endtask

  task automatic pulse_env();
    @(negedge clk); mem_load = 1'b1; mon_clr = 1'b1;
    @(negedge clk); mem_load = 1'b0; mon_clr = 1'b0;
  endtask

  task automatic wait_irq();
    for (int i = 0; i < 4000 && !irq; i++) @(negedge clk);
  endtask

  task automatic run_xfer(input logic [15:0] start, input int cnt, input bit dir,
                          input int gd, input bit slow, input bit meddle);
    logic [RW-1:0] rd;
    gnt_dly = gd; rdy_slow = slow; src_seed = 8'(start + 8'h5a);
    pulse_env();
    reg_write(2'd0, RW'(start));
    reg_write(2'd1, RW'(cnt));
    reg_write(2'd2, RW'({dir, 1'b1}));
    if (cnt == 0) begin
      check(irq === 1'b1, "R10 irq on zero count", irq, 1);
    end else begin
      reg_read(2'd2, rd);
      check(rd[0] === 1'b1, "R11 busy while active", rd[0], 1);
    end
    if (meddle) begin
      reg_write(2'd0, 32'h1234);
      reg_write(2'd1, 32'h55);
      reg_write(2'd2, RW'({!dir, 1'b1}));
    end
    wait_irq();
    check(irq === 1'b1, "R9 completion irq", irq, 1);
    repeat (2) @(negedge clk);
    reg_read(2'd2, rd);
    check(rd[0] === 1'b0, "R9 busy cleared", rd[0], 0);
    check(rd[1] === 1'b1, "R1 status irq bit", rd[1], 1);
    check(rd[2] === dir, "R2 direction bit", rd[2], dir);
    reg_read(2'd0, rd);
    check(rd === RW'(16'(start + cnt)), "R8 final address", rd, RW'(16'(start + cnt)));
    reg_read(2'd1, rd);
    check(rd === '0, "R8 final count", rd, 0);
    check(own_n == cnt, "R5 one request per unit", own_n, cnt);
    check(bad_n == 0, "R4 strobe without grant", bad_n, 0);
    check(late_n == 0, "R5 request after write", late_n, 0);
    if (cnt == 0) check(src_n + sink_n == 0, "R10 no bus activity", src_n + sink_n, 0);
    if (!dir) begin
      check(sink_n == cnt, "R6 device write count", sink_n, cnt);
      for (int k = 0; k < cnt; k++) begin
        logic [7:0] ex;
        ex = 8'((16'(start + k) % 256) * 7 + 3);
        check(sink[k] === ex, "R6 byte to device", sink[k], ex);
      end
    end else begin
      check(src_n == cnt, "R7 device read count", src_n, cnt);
      for (int k = 0; k < cnt; k++) begin
        logic [7:0] ex;
        ex = 8'(src_seed + k * 13);
        check(mem[8'(start + k)] === ex, "R7 byte to memory", mem[8'(start + k)], ex);
      end
    end
    check(irq === 1'b1, "R9 irq held", irq, 1);
    reg_write(2'd2, 32'h4);
    check(irq === 1'b0, "R9 irq cleared", irq, 0);
  endtask

  initial begin
    logic [RW-1:0] rd;
    #200_000;
    check(1'b0, "watchdog", 0, 1);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [RW-1:0] rd;
    int cnts [5] = '{0, 1, 2, 3, 7};
    int run = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(irq === 1'b0, "R9 reset irq", irq, 0);
    check(req === 1'b0, "R5 reset request", req, 0);
    reg_read(2'd2, rd);
    check(rd === '0, "R1 reset status", rd, 0);
    reg_read(2'd0, rd);
    check(rd === '0, "R1 reset address", rd, 0);
    reg_read(2'd1, rd);
    check(rd === '0, "R1 reset count", rd, 0);

    for (int d = 0; d < 2; d++)
      for (int c = 0; c < 5; c++)
        for (int g = 0; g < 2; g++)
          for (int s = 0; s < 2; s++) begin
            run_xfer(16'(16'h0100 + run * 5), cnts[c], d[0], g * 3, s[0], 1'b0);
            run++;
          end

    // R8 address wrap
    run_xfer(16'hFFFE, 4, 1'b1, 1, 1'b0, 1'b0);
    run_xfer(16'hFFFD, 5, 1'b0, 0, 1'b1, 1'b0);
    // R2 writes and restart ignored while busy
    run_xfer(16'h0020, 4, 1'b0, 2, 1'b1, 1'b1);
    run_xfer(16'h0030, 3, 1'b1, 0, 1'b1, 1'b1);
    // R3 no request while device never ready
    pulse_env();
    @(negedge clk); rdy_slow = 1'b1; gnt_dly = 0;
    force dev_ready = 1'b0;
    reg_write(2'd0, 32'h40);
    reg_write(2'd1, 32'h2);
    reg_write(2'd2, 32'h1);
    repeat (10) @(negedge clk);
    check(req === 1'b0, "R3 no request without ready", req, 0);
    release dev_ready;
    wait_irq();
    check(irq === 1'b1, "R3 completes once ready", irq, 1);
    reg_write(2'd2, 32'h4);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule